// File: doc/BRIEF.md
# Sticky Fault Register with Alert Control

This block holds the fault record of a power-switch controller. Six latched bits capture fault-detect pulses, and one of them (bit 4) doubles as a record that the enable input changed state. Each bit stays set until something clears it. Clearing can come from a host write, a switch turn-off, a filtered undervoltage condition, an internal-supply lockout, or a falling enable input. Each of these sources clears its own subset of bits. A bit whose live status input still reports the fault cannot be cleared by any of them.

The block also drives an open-drain alert pull-down. The alert fires once for each new fault bit, and the host's alert-response acknowledge releases it. A fault that keeps repeating while its bit is still set stays silent. A general-purpose override can force the pin low instead. While that override is on, the block must not answer the alert response address.

Finally, the block produces a switch hold-off signal. Its source depends on the auto-retry setting:
- With auto-retry off, the latched bits drive it.
- With auto-retry on, only the live status drives it.

An overcurrent pulse forces hold-off in the same cycle it arrives.

Top module: `flt_alert_latch`

## Requirements
- R1: A cycle with `wr_stb` high clears every fault bit whose `wr_data` bit is 0. Data bits of 1 leave the register unchanged.
- R2: No clear source of any kind clears a fault bit i while `live_stat[i]` is 1.
- R3: A falling edge of `on_pin` (after synchronisation), a falling edge of `on_ctl`, or a high level on `uvlo` (after synchronisation) clears all six bits.
- R4: A synchronised `uv_below` held high for `UV_HOLD_CYC` consecutive cycles clears all six bits. A shorter run clears nothing.
- R5: A synchronised falling edge of `en_pin` clears bits 0, 1, 2, 3 and 5, and sets bit 4.
- R6: A fault bit going from 0 to 1 raises the pending alert. `ara_ack` releases it. Further set pulses on a bit that is already set raise no new alert until that bit has been cleared.
- R7: With `gpo_force` at 1, `alert_pull_o` is 1 and `ara_resp_en_o` is 0. With `gpo_force` at 0, `alert_pull_o` follows the pending alert and `ara_resp_en_o` equals it.
- R8: With `auto_retry` at 0, `hold_off_o` is 1 exactly when any of fault bits 0, 1 or 2 is set (or an overcurrent pulse is present).
- R9: With `auto_retry` at 1, `hold_off_o` is 1 only while `live_stat[0]` or `live_stat[1]` is 1 (or an overcurrent pulse is present). The latched bits are ignored and are not altered.
- R10: A pulse on `flt_set_p[2]` (overcurrent) raises `hold_off_o` in the same cycle and sets bit 2 on the next clock edge.
- R11: If a set pulse and a clear event act on the same bit in the same cycle, the bit ends up set.
- R12: After reset the fault register is 0, no alert is pending, and `alert_pull_o`, `ara_resp_en_o` and `hold_off_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_set_p | input | 6 | One-cycle fault-detect pulses, one per bit (bit 2 = overcurrent) |
| live_stat | input | 6 | Live fault condition levels; a 1 blocks clearing of that bit |
| wr_stb | input | 1 | Host write strobe for the fault register |
| wr_data | input | 6 | Host write data; 0 bits request a clear |
| on_pin | input | 1 | Asynchronous switch-on pin |
| on_ctl | input | 1 | Synchronous switch-on control bit |
| en_pin | input | 1 | Asynchronous enable pin |
| uv_below | input | 1 | Asynchronous undervoltage-below-reset-level indicator |
| uvlo | input | 1 | Asynchronous internal-supply lockout indicator |
| auto_retry | input | 1 | 1 selects auto-retry hold-off behaviour |
| gpo_force | input | 1 | General-purpose override pulling the alert pin low |
| ara_ack | input | 1 | Alert response acknowledged by host; releases the alert |
| fault_o | output | 6 | Latched fault register |
| alert_pull_o | output | 1 | 1 enables the open-drain pull-down on the alert pin |
| ara_resp_en_o | output | 1 | 1 allows answering the alert response address |
| hold_off_o | output | 1 | 1 keeps the power switch off |

## Verification
The bench builds the block with `SYNC_STAGES` = 2 and `UV_HOLD_CYC` = 4. With these values the undervoltage filter boundary can be probed at one cycle below the limit and exactly at it in a handful of clocks. The register is only six bits wide, so every write pattern can be swept against several live-status masks. Likewise, every combination of the three hold-off bits, the retry mode and the two live bits is covered, each against an expected value computed arithmetically.

// File: rtl/flt_alert_pkg.sv
package flt_alert_pkg;

    localparam int NFLT    = 6;
    localparam int EVT_BIT = 4;
    localparam int OC_BIT  = 2;

    typedef logic [NFLT-1:0] flt_vec_t;

    localparam flt_vec_t ALL_MASK    = '1;
    localparam flt_vec_t EVT_ONEHOT  = flt_vec_t'(1) << EVT_BIT;
    localparam flt_vec_t EN_FALL_CLR = ALL_MASK & ~EVT_ONEHOT;

    // decoded clear events, one cycle wide
    typedef struct packed {
        logic clr_all;
        logic en_fall;
    } clr_evt_t;

    // bits that the present events ask to clear (before live-status guard)
    function automatic flt_vec_t clear_mask(clr_evt_t ev, logic wr, flt_vec_t wd);
        flt_vec_t m;
        m = '0;
        if (wr)         m = m | ~wd;
        if (ev.en_fall) m = m | EN_FALL_CLR;
        if (ev.clr_all) m = ALL_MASK;
        return m;
    endfunction

    // switch hold-off selection
    function automatic logic hold_calc(logic retry, flt_vec_t fq, flt_vec_t lv, logic oc_p);
        logic h;
        if (retry) h = lv[0] | lv[1];
        else       h = |fq[2:0];
        return h | oc_p;
    endfunction

endpackage

// File: rtl/flt_sync.sv
module flt_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stg;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= '0;
                else     stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];

endmodule

// File: rtl/flt_evt_detect.sv
module flt_evt_detect
    import flt_alert_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int UV_HOLD_CYC = 500
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     on_pin,
    input  logic     on_ctl,
    input  logic     en_pin,
    input  logic     uv_below,
    input  logic     uvlo,
    output clr_evt_t ev
);

    localparam int CW = $clog2(UV_HOLD_CYC + 1);

    logic [3:0] pin_s;
    logic on_s, en_s, uv_s, uvlo_s;
    logic on_prev, en_prev, ctl_prev;
    logic [CW-1:0] uv_cnt;
    logic uv_fire;

    flt_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({uvlo, uv_below, en_pin, on_pin}),
        .q   (pin_s)
    );

    assign {uvlo_s, uv_s, en_s, on_s} = pin_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            on_prev  <= 1'b0;
            en_prev  <= 1'b0;
            ctl_prev <= 1'b0;
        end else begin
            on_prev  <= on_s;
            en_prev  <= en_s;
            ctl_prev <= on_ctl;
        end
    end

    // undervoltage run-length filter, saturates at the limit
    always_ff @(posedge clk) begin
        if (rst || !uv_s)                   uv_cnt <= '0;
        else if (uv_cnt != CW'(UV_HOLD_CYC)) uv_cnt <= uv_cnt + 1'b1;
    end

    assign uv_fire = uv_s && (uv_cnt == CW'(UV_HOLD_CYC - 1));

    always_comb begin
        ev.clr_all = (on_prev & ~on_s) | (ctl_prev & ~on_ctl) | uv_fire | uvlo_s;
        ev.en_fall = en_prev & ~en_s;
    end

endmodule

// File: rtl/flt_reg_core.sv
module flt_reg_core
    import flt_alert_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  flt_vec_t flt_set_p,
    input  flt_vec_t live_stat,
    input  logic     wr_stb,
    input  flt_vec_t wr_data,
    input  clr_evt_t ev,
    input  logic     ara_ack,
    output flt_vec_t fault_q,
    output logic     alert_pend,
    output flt_vec_t fault_rise
);

    flt_vec_t set_v, clr_v, fault_nxt;
    logic     alert_nxt;

    always_comb begin
        set_v      = flt_set_p | (ev.en_fall ? EVT_ONEHOT : '0);
        clr_v      = clear_mask(ev, wr_stb, wr_data) & ~live_stat;
        fault_nxt  = (fault_q & ~clr_v) | set_v;
        fault_rise = fault_nxt & ~fault_q;
        alert_nxt  = (|fault_rise) | (alert_pend & ~ara_ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q    <= '0;
            alert_pend <= 1'b0;
        end else begin
            fault_q    <= fault_nxt;
            alert_pend <= alert_nxt;
        end
    end

endmodule

// File: rtl/flt_alert_latch.sv
module flt_alert_latch
    import flt_alert_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int UV_HOLD_CYC = 500
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NFLT-1:0] flt_set_p,
    input  logic [NFLT-1:0] live_stat,
    input  logic            wr_stb,
    input  logic [NFLT-1:0] wr_data,
    input  logic            on_pin,
    input  logic            on_ctl,
    input  logic            en_pin,
    input  logic            uv_below,
    input  logic            uvlo,
    input  logic            auto_retry,
    input  logic            gpo_force,
    input  logic            ara_ack,
    output logic [NFLT-1:0] fault_o,
    output logic            alert_pull_o,
    output logic            ara_resp_en_o,
    output logic            hold_off_o
);

    clr_evt_t ev;
    flt_vec_t fault_q;
    flt_vec_t fault_rise;
    logic     alert_pend;

    flt_evt_detect #(
        .SYNC_STAGES (SYNC_STAGES),
        .UV_HOLD_CYC (UV_HOLD_CYC)
    ) u_evt (
        .clk      (clk),
        .rst      (rst),
        .on_pin   (on_pin),
        .on_ctl   (on_ctl),
        .en_pin   (en_pin),
        .uv_below (uv_below),
        .uvlo     (uvlo),
        .ev       (ev)
    );

    flt_reg_core u_core (
        .clk        (clk),
        .rst        (rst),
        .flt_set_p  (flt_set_p),
        .live_stat  (live_stat),
        .wr_stb     (wr_stb),
        .wr_data    (wr_data),
        .ev         (ev),
        .ara_ack    (ara_ack),
        .fault_q    (fault_q),
        .alert_pend (alert_pend),
        .fault_rise (fault_rise)
    );

    assign fault_o       = fault_q;
    assign alert_pull_o  = gpo_force | alert_pend;
    assign ara_resp_en_o = alert_pend & ~gpo_force;
    assign hold_off_o    = hold_calc(auto_retry, fault_q, live_stat, flt_set_p[OC_BIT]);

endmodule

// File: rtl/flt_alert_chk.sv
module flt_alert_chk
    import flt_alert_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [NFLT-1:0] flt_set_p,
    input logic [NFLT-1:0] live_stat,
    input logic            wr_stb,
    input logic [NFLT-1:0] wr_data,
    input logic            auto_retry,
    input logic            gpo_force,
    input logic            ara_ack,
    input logic [NFLT-1:0] fault_o,
    input logic            alert_pull_o,
    input logic            ara_resp_en_o,
    input logic            hold_off_o,
    input logic            alert_pend,
    input logic [NFLT-1:0] fault_rise
);

    for (genvar i = 0; i < NFLT; i++) begin : g_bit
        if (i != EVT_BIT) begin : g_wr
            a_r1_wr_zero_clears: assert property (@(posedge clk) disable iff (rst)
                wr_stb && !wr_data[i] && !live_stat[i] && !flt_set_p[i] |=> !fault_o[i]);
        end
        a_r2_live_guard: assert property (@(posedge clk) disable iff (rst)
            fault_o[i] && live_stat[i] |=> fault_o[i]);
        a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
            flt_set_p[i] |=> fault_o[i]);
    end

    a_r6_quiet_without_rise: assert property (@(posedge clk) disable iff (rst)
        !(|fault_rise) && !alert_pend |=> !alert_pend);

    a_r6_ack_releases: assert property (@(posedge clk) disable iff (rst)
        alert_pend && ara_ack && !(|fault_rise) |=> !alert_pend);

    a_r7_force_low: assert property (@(posedge clk) disable iff (rst)
        gpo_force |-> alert_pull_o && !ara_resp_en_o);

    a_r8_latched_hold: assert property (@(posedge clk) disable iff (rst)
        !auto_retry && (|fault_o[2:0]) |-> hold_off_o);

    a_r9_live_only: assert property (@(posedge clk) disable iff (rst)
        auto_retry && !live_stat[0] && !live_stat[1] && !flt_set_p[OC_BIT] |-> !hold_off_o);

    a_r10_oc_off: assert property (@(posedge clk) disable iff (rst)
        flt_set_p[OC_BIT] |-> hold_off_o);

endmodule

bind flt_alert_latch flt_alert_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .flt_set_p     (flt_set_p),
    .live_stat     (live_stat),
    .wr_stb        (wr_stb),
    .wr_data       (wr_data),
    .auto_retry    (auto_retry),
    .gpo_force     (gpo_force),
    .ara_ack       (ara_ack),
    .fault_o       (fault_o),
    .alert_pull_o  (alert_pull_o),
    .ara_resp_en_o (ara_resp_en_o),
    .hold_off_o    (hold_off_o),
    .alert_pend    (alert_pend),
    .fault_rise    (fault_rise)
);

// File: tb/test_flt_alert_latch.sv
`timescale 1ns/1ps
module test_flt_alert_latch;

    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] flt_set_p = '0, live_stat = '0, wr_data = '0;
    logic       wr_stb = 0, on_pin = 0, on_ctl = 0, en_pin = 0, uv_below = 0, uvlo = 0;
    logic       auto_retry = 0, gpo_force = 0, ara_ack = 0;
    logic [5:0] fault_o;
    logic       alert_pull_o, ara_resp_en_o, hold_off_o;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    flt_alert_latch #(.SYNC_STAGES(2), .UV_HOLD_CYC(HOLD)) i_flt_alert_latch (
        .clk(clk), .rst(rst), .flt_set_p(flt_set_p), .live_stat(live_stat),
        .wr_stb(wr_stb), .wr_data(wr_data), .on_pin(on_pin), .on_ctl(on_ctl),
        .en_pin(en_pin), .uv_below(uv_below), .uvlo(uvlo), .auto_retry(auto_retry),
        .gpo_force(gpo_force), .ara_ack(ara_ack), .fault_o(fault_o),
        .alert_pull_o(alert_pull_o), .ara_resp_en_o(ara_resp_en_o), .hold_off_o(hold_off_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_set(input logic [5:0] v);
        flt_set_p = v; cyc(1); flt_set_p = '0;
    endtask

    task automatic wr(input logic [5:0] d);
        wr_stb = 1'b1; wr_data = d; cyc(1); wr_stb = 1'b0; wr_data = '0;
    endtask

    task automatic ack();
        ara_ack = 1'b1; cyc(1); ara_ack = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog act=timeout exp=completion");
        summary();
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // R12 reset state
        chk("R12 fault", fault_o, 6'h00);
        chk("R12 pull", alert_pull_o, 1'b0);
        chk("R12 ara", ara_resp_en_o, 1'b0);
        chk("R12 hold", hold_off_o, 1'b0);

        // R1 / R2 sweep: all write patterns against several live masks
        for (int lvi = 0; lvi < 3; lvi++) begin
            for (int d = 0; d < 64; d++) begin
                logic [5:0] lv;
                lv = (lvi == 0) ? 6'h00 : (lvi == 1) ? 6'h15 : 6'h2A;
                live_stat = '0;
                pulse_set(6'h3F);
                live_stat = lv;
                wr(6'(d));
                chk(lv == 0 ? "R1 write clear" : "R2 live guard on write",
                    fault_o, 6'(d) | lv);
            end
        end
        live_stat = '0;

        // R6 alert once per new fault
        wr(6'h00); ack(); cyc(1);
        chk("R6 idle pull", alert_pull_o, 1'b0);
        pulse_set(6'h01);
        chk("R6 raise pull", alert_pull_o, 1'b1);
        chk("R6 raise ara", ara_resp_en_o, 1'b1);
        ack();
        chk("R6 released", alert_pull_o, 1'b0);
        pulse_set(6'h01); cyc(1);
        chk("R6 repeat quiet", alert_pull_o, 1'b0);
        pulse_set(6'h02);
        chk("R6 other bit raises", alert_pull_o, 1'b1);
        ack();
        wr(6'h3E);
        chk("R6 bit0 cleared", fault_o, 6'h02);
        chk("R6 clear no alert", alert_pull_o, 1'b0);
        pulse_set(6'h01);
        chk("R6 re-set raises", alert_pull_o, 1'b1);
        ack();

        // R7 override
        gpo_force = 1'b1; #1;
        chk("R7 force pull", alert_pull_o, 1'b1);
        chk("R7 force ara", ara_resp_en_o, 1'b0);
        cyc(1);
        pulse_set(6'h08);
        chk("R7 pending forced ara", ara_resp_en_o, 1'b0);
        gpo_force = 1'b0; #1;
        chk("R7 pending pull", alert_pull_o, 1'b1);
        chk("R7 pending ara", ara_resp_en_o, 1'b1);
        cyc(1); ack();
        chk("R7 hi-z", alert_pull_o, 1'b0);

        // R3 on pin, on control bit, lockout
        pulse_set(6'h3F); on_pin = 1'b1; cyc(6);
        chk("R3 on rise keeps", fault_o, 6'h3F);
        on_pin = 1'b0; cyc(6);
        chk("R3 on pin fall", fault_o, 6'h00);
        pulse_set(6'h3F); on_ctl = 1'b1; cyc(2);
        live_stat = 6'h05;
        on_ctl = 1'b0; cyc(2);
        chk("R2 live guard on ctl fall", fault_o, 6'h05);
        live_stat = '0;
        pulse_set(6'h3F); uvlo = 1'b1; cyc(6); uvlo = 1'b0; cyc(2);
        chk("R3 uvlo", fault_o, 6'h00);

        // R4 undervoltage filter
        pulse_set(6'h3F);
        uv_below = 1'b1; cyc(HOLD - 1); uv_below = 1'b0; cyc(6);
        chk("R4 short run", fault_o, 6'h3F);
        uv_below = 1'b1; cyc(HOLD); uv_below = 1'b0; cyc(6);
        chk("R4 full run", fault_o, 6'h00);

        // R5 enable fall
        en_pin = 1'b1; cyc(6);
        pulse_set(6'h3F);
        en_pin = 1'b0; cyc(6);
        chk("R5 en fall from all", fault_o, 6'h10);
        wr(6'h00);
        en_pin = 1'b1; cyc(6); en_pin = 1'b0; cyc(6);
        chk("R5 en fall from none", fault_o, 6'h10);

        // R8 / R9 hold-off sweep
        for (int f = 0; f < 8; f++) begin
            live_stat = '0;
            wr(6'h00);
            pulse_set(6'(f));
            for (int r = 0; r < 2; r++) begin
                for (int lv = 0; lv < 4; lv++) begin
                    logic e;
                    auto_retry = r[0];
                    live_stat = 6'(lv);
                    #1;
                    e = r[0] ? (lv != 0) : (f != 0);
                    chk(r[0] ? "R9 retry hold" : "R8 latched hold", hold_off_o, e);
                    chk("R9 register untouched", fault_o, 6'(f));
                end
            end
        end
        live_stat = '0; auto_retry = 1'b1;

        // R10 overcurrent
        wr(6'h00); cyc(1);
        flt_set_p = 6'h04; #1;
        chk("R10 same-cycle hold", hold_off_o, 1'b1);
        cyc(1); flt_set_p = '0;
        chk("R10 bit2 set", fault_o, 6'h04);
        auto_retry = 1'b0;

        // R11 set beats clear
        wr(6'h00);
        on_ctl = 1'b1; cyc(2);
        on_ctl = 1'b0; flt_set_p = 6'h01; cyc(1); flt_set_p = '0;
        chk("R11 set vs on fall", fault_o, 6'h01);
        wr_stb = 1'b1; wr_data = 6'h00; flt_set_p = 6'h20; cyc(1);
        wr_stb = 1'b0; flt_set_p = '0;
        chk("R11 set vs write", fault_o, 6'h20);

        summary();
        $finish;
    end

endmodule